// File: doc/BRIEF.md
# Half-Bridge Dead-Band Delay Generator

This block turns one raw PWM level into a complementary pair of gate drives for a half-bridge. The high-side drive follows the PWM level and the low-side drive follows its inverse. The two drives are never active at the same moment. When the PWM level changes, the drive that is losing its turn drops at once. The drive that gains its turn stays off for a programmable number of instruction cycles. This dead time gives the opposite power switch time to turn off fully before its partner turns on.

Time in the block moves only on an instruction-cycle enable tick. The integration asserts this tick for one clock in every four oscillator periods. The dead time is a count of such ticks, set by a 7-bit input. A count of zero gives no dead time. The PWM period, duty cycle, output polarity and any shutdown behaviour are produced outside this block.

Top module: `dead_band_pair`

## Requirements
- R1: While reset is asserted, both drives are low. The first enable tick after reset begins a dead-band interval for whichever side the PWM level selects at that tick.
- R2: The high drive is active only while the sampled PWM level is 1, and the low drive only while it is 0. The drives change only on clock edges where the enable tick is 1.
- R3: The high and low drives are never both active.
- R4: On the enable tick where the sampled PWM level differs from the level of the current side, the drive of the old side goes low at that clock edge.
- R5: With a delay count D from 1 to 127 sampled at the level-change tick, the new side's drive goes high at the clock edge of the D-th enable tick after that level-change tick. One tick is one instruction cycle, which is four oscillator periods.
- R6: With a delay count of 0, the new side's drive goes high at the clock edge of the level-change tick itself.
- R7: If the PWM level reverses before a pending activation completes, that activation is cancelled. A new interval starts for the other side and counts from the reversing tick.
- R8: The delay count is sampled only on the tick that starts a dead-band interval. A change to it during an interval has no effect on that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_tick | input | 1 | Instruction-cycle enable, one clock in four |
| pwm_in | input | 1 | Raw PWM level |
| dly_cnt | input | 7 | Dead time in instruction cycles (0 to 127) |
| drv_hi | output | 1 | High-side drive, active high |
| drv_lo | output | 1 | Low-side drive, active high |

## Verification
The hardest case to reach is a PWM level that reverses while an activation is still pending, and this becomes harder when the delay count also changes during the interval. The stimulus covers it in two ways. One pass toggles the PWM level more often than the programmed dead time, so every activation is cancelled. Another pass rewrites the delay count a few ticks into an interval. A final phase drives the enable tick and the PWM level from a pseudo-random sequence. A behavioural model that counts ticks from the last level change is compared against both drives on every clock.

// File: rtl/dead_band_pair.sv
module dead_band_pair #(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             pwm_in,
  input  logic [DLY_W-1:0] dly_cnt,
  output logic             drv_hi,
  output logic             drv_lo
);

  logic             started;
  logic             side;
  logic             on;
  logic [DLY_W-1:0] cnt;

  wire level_change = !started || (pwm_in != side);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      side    <= 1'b0;
      on      <= 1'b0;
      cnt     <= '0;
    end else if (cyc_tick) begin
      if (level_change) begin
        started <= 1'b1;
        side    <= pwm_in;
        on      <= (dly_cnt == '0);
        cnt     <= dly_cnt;
      end else if (!on) begin
        cnt <= cnt - 1'b1;
        if (cnt == DLY_W'(1)) on <= 1'b1;
      end
    end
  end

  assign drv_hi = on & side;
  assign drv_lo = on & ~side;

endmodule

module dead_band_pair_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_tick,
  input logic pwm_in,
  input logic drv_hi,
  input logic drv_lo
);

  // R3
  both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo));

  // R2
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_tick |=> $stable(drv_hi) && $stable(drv_lo));

  // R4
  hi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_tick && !pwm_in |=> !drv_hi);

  // R4
  lo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_tick && pwm_in |=> !drv_lo);

  // R2
  hi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi) |-> $past(cyc_tick) && $past(pwm_in));

  // R2
  lo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_lo) |-> $past(cyc_tick) && !$past(pwm_in));

endmodule

bind dead_band_pair dead_band_pair_chk u_chk (.*);

// File: tb/test_dead_band_pair.sv
module test_dead_band_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       pwm_in = 1'b0;
  logic [6:0] dly_cnt = 7'd0;
  logic       drv_hi, drv_lo;

  int    checks = 0;
  int    fails = 0;
  string req = "R1";
  bit    rand_tick = 1'b0;
  int    clk_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  dead_band_pair i_dead_band_pair (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .pwm_in(pwm_in),
    .dly_cnt(dly_cnt), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  always #10 clk = ~clk;

  // behavioural reference: ticks elapsed since the last level change
  int m_started, m_level, m_since, m_delay;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_started = 0; m_level = 0; m_since = 0; m_delay = 0;
    end else if (cyc_tick) begin
      if (m_started == 0 || int'(pwm_in) != m_level) begin
        m_started = 1; m_level = int'(pwm_in); m_since = 0; m_delay = int'(dly_cnt);
      end else if (m_since < 100000) begin
        m_since++;
      end
    end
  end

  function automatic bit exp_on();
    return (m_started == 1) && (m_since >= m_delay);
  endfunction

  always @(negedge clk) begin
    bit eh, el;
    eh = exp_on() && (m_level == 1);
    el = exp_on() && (m_level == 0);
    checks += 2;
    if (drv_hi !== eh) begin
      fails++;
      $display("FAIL %s drv_hi actual=%b expected=%b at clk %0d", req, drv_hi, eh, clk_cnt);
    end
    if (drv_lo !== el) begin
      fails++;
      $display("FAIL %s drv_lo actual=%b expected=%b at clk %0d", req, drv_lo, el, clk_cnt);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rand_tick) cyc_tick = lfsr[0] & lfsr[3];
    else cyc_tick = (clk_cnt % 4 == 3);
    clk_cnt++;
  end

  always @(posedge clk) begin
    if (clk_cnt > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    req = "R1";
    dly_cnt = 7'd3;
    run(6);
    rst_n = 1'b1;
    run(40);
    req = "R5"; pwm_in = 1'b1; run(40);
    req = "R4"; pwm_in = 1'b0; run(40);
    req = "R6"; dly_cnt = 7'd0;
    for (int k = 0; k < 6; k++) begin pwm_in = ~pwm_in; run(12); end
    req = "R7"; dly_cnt = 7'd10;
    for (int k = 0; k < 8; k++) begin pwm_in = ~pwm_in; run(20); end
    run(60);
    req = "R8"; dly_cnt = 7'd5; pwm_in = 1'b1; run(10);
    dly_cnt = 7'd60; run(40);
    pwm_in = 1'b0; run(10);
    dly_cnt = 7'd1; run(260);
    req = "R5"; dly_cnt = 7'd127; pwm_in = 1'b1; run(560);
    pwm_in = 1'b0; run(560);
    dly_cnt = 7'd1; pwm_in = 1'b1; run(20);
    req = "R2"; rand_tick = 1'b1;
    for (int k = 0; k < 300; k++) begin
      if (lfsr[5] & lfsr[9]) pwm_in = ~pwm_in;
      dly_cnt = 7'(lfsr[6:0] & 7'h0F);
      run(8);
    end
    req = "R3"; rand_tick = 1'b0; dly_cnt = 7'd2;
    for (int k = 0; k < 30; k++) begin pwm_in = ~pwm_in; run(3 + (k % 13)); end
    req = "R1"; rst_n = 1'b0; run(5);
    rst_n = 1'b1; pwm_in = 1'b1; dly_cnt = 7'd4; run(40);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule